// File: doc/BRIEF.md
# ADC Result Accumulator and Formatter

This block turns a stream of 10-bit conversion results into a 16-bit result word that a host can read and write. Each conversion arrives with a one-cycle strobe. An 8-bit configuration register sets three things: whether conversions are summed outside burst mode, how the stored value is presented on the read port, and how many conversions one burst adds together.

Burst mode is selected by a level input. In that mode a two-state sequencer runs. In `ST_IDLE`, the first strobe of a burst starts a new partial sum from zero. If the burst holds more than one sample, the sequencer takes the transition *start* into `ST_GATHER`; a one-sample burst finishes at once and stays in `ST_IDLE`. In `ST_GATHER`, each strobe adds to the partial sum. When the last sample of the burst is added, the sequencer takes the transition *finish* back to `ST_IDLE`, copies the total into the result register and pulses `burst_done` for one cycle. If burst mode is dropped, the sequencer takes the transition *abort* back to `ST_IDLE` and discards the partial sum.

With burst mode off, each conversion either replaces the stored value or is added to it, depending on the accumulate bit. An accumulated sum stays until the host writes the result register. The read port shows the stored value shifted right, or left-justified. The stored value itself is never changed by the read format.

Top module: `adc_accum_fmt`

## Requirements
- R1: After reset, `cfg_rdata`, `res_rdata` and `burst_done` are all 0.
- R2: A configuration write stores the accumulate bit from bit 6, the format code from bits 5:3 and the repeat code from bits 2:0. A read returns the format and repeat codes in the same positions, and bits 7 and 6 always read 0.
- R3: A format code above 4 or a repeat code above 5 is stored, read back and used as 0.
- R4: With burst off and the accumulate bit clear, every conversion strobe replaces the stored value with the zero-extended 10-bit sample.
- R5: With burst off and the accumulate bit set, every strobe adds the sample to the stored value. A host write loads the written value, so writing 0x0000 clears the sum.
- R6: Format codes 0, 1, 2 and 3 show the stored value shifted right by 0, 1, 2 and 3 bits on `res_rdata`.
- R7: Format code 4 shows stored bits 9:0 in `res_rdata` bits 15:6, with bits 5:0 zero.
- R8: In burst mode, repeat codes 0 to 5 select bursts of 1, 4, 8, 16, 32 and 64 samples. On the edge that takes the last sample, the stored value becomes the sum of exactly that burst, starting from zero, and `burst_done` is high for that one cycle.
- R9: While a burst is in progress, the stored value and `burst_done` stay unchanged.
- R10: Dropping burst mode in the middle of a burst discards the partial sum. The next burst starts again from zero.
- R11: A 64-sample burst of 1023 gives exactly 65472, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| burst_en | input | 1 | Burst mode select (level) |
| conv_done | input | 1 | One-cycle conversion strobe |
| conv_data | input | 10 | Conversion sample |
| res_we | input | 1 | Host write strobe for the result register |
| res_wdata | input | 16 | Host write data for the result register |
| res_rdata | output | 16 | Formatted result view |
| burst_done | output | 1 | One-cycle pulse when a burst completes |

## Verification
The bench sweeps every configuration byte pattern and checks it against the field rules. A design that does not remap reserved codes, or that lets the write-only bit read back, reports a wrong byte. Every repeat code is run as a full burst, and both the pulse and the stored value are checked sample by sample. This catches an off-by-one burst length, a sum seeded from the old result, a stored value that changes before the burst ends, or a pulse longer than one cycle. An all-ones 64-sample burst exposes a truncated accumulator. An aborted burst shows whether a stale partial sum leaks into the next burst. Each format code is applied to several stored patterns, which exposes a wrong shift amount or a left-justify that takes the wrong bits.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;

    typedef enum logic [2:0] {
        FMT_R0 = 3'd0,
        FMT_R1 = 3'd1,
        FMT_R2 = 3'd2,
        FMT_R3 = 3'd3,
        FMT_LJ = 3'd4
    } fmt_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_GATHER = 1'b1
    } bst_e;

    localparam logic [2:0] FMT_MAX = 3'd4;
    localparam logic [2:0] RPT_MAX = 3'd5;

    function automatic logic [2:0] clean_fmt(input logic [2:0] code);
        return (code <= FMT_MAX) ? code : 3'd0;
    endfunction

    function automatic logic [2:0] clean_rpt(input logic [2:0] code);
        return (code <= RPT_MAX) ? code : 3'd0;
    endfunction

    // code 0 -> 1 sample, code k (1..5) -> 2^(k+1) samples
    function automatic int unsigned burst_len(input logic [2:0] code);
        if (code == 3'd0) return 1;
        return 32'd1 << (int'(code) + 1);
    endfunction

endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
    import adc_acc_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic             acc_en,
    output fmt_e             fmt,
    output logic [2:0]       rpt,
    output logic [CFG_W-1:0] rdata
);
    logic unused_rsvd;
    assign unused_rsvd = wdata[7];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_en <= 1'b0;
            fmt    <= FMT_R0;
            rpt    <= 3'd0;
        end else if (we) begin
            acc_en <= wdata[6];
            fmt    <= fmt_e'(clean_fmt(wdata[5:3]));
            rpt    <= clean_rpt(wdata[2:0]);
        end
    end

    always_comb begin
        rdata      = '0;
        rdata[5:3] = fmt;
        rdata[2:0] = rpt;
    end
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
    import adc_acc_pkg::*;
#(
    parameter int CONV_W = 10,
    parameter int ACC_W  = 16,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              conv_done,
    input  logic [CONV_W-1:0] conv_data,
    input  logic [2:0]        rpt,
    output logic              fin,
    output logic [ACC_W-1:0]  fin_sum,
    output logic              done_q
);
    bst_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_now, target;
    logic [ACC_W-1:0] part_q, base;
    logic             take;

    assign take    = burst_en && conv_done;
    assign target  = CNT_W'(burst_len(rpt));
    assign base    = (state_q == ST_GATHER) ? part_q : '0;
    assign cnt_now = ((state_q == ST_GATHER) ? cnt_q : '0) + CNT_W'(1);
    assign fin_sum = base + {{(ACC_W-CONV_W){1'b0}}, conv_data};
    assign fin     = take && (cnt_now >= target);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take && !fin) state_d = ST_GATHER;      // start
            ST_GATHER: if (!burst_en)    state_d = ST_IDLE;        // abort
                       else if (fin)     state_d = ST_IDLE;        // finish
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (take) begin
                part_q <= fin_sum;
                cnt_q  <= cnt_now;
            end
        end
    end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int CONV_W = 10,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ACC_W-1:0]  host_wdata,
    input  logic              burst_en,
    input  logic              conv_done,
    input  logic [CONV_W-1:0] conv_data,
    input  logic              acc_en,
    input  logic              fin,
    input  logic [ACC_W-1:0]  fin_sum,
    output logic [ACC_W-1:0]  res_q
);
    logic [ACC_W-1:0] sample;
    assign sample = {{(ACC_W-CONV_W){1'b0}}, conv_data};

    always_ff @(posedge clk) begin
        if (!rst_n)                   res_q <= '0;
        else if (host_we)             res_q <= host_wdata;
        else if (fin)                 res_q <= fin_sum;
        else if (!burst_en && conv_done)
            res_q <= acc_en ? (res_q + sample) : sample;
    end
endmodule

// File: rtl/adc_read_fmt.sv
module adc_read_fmt
    import adc_acc_pkg::*;
#(
    parameter int CONV_W = 10,
    parameter int ACC_W  = 16
) (
    input  logic [ACC_W-1:0] res,
    input  fmt_e             fmt,
    output logic [ACC_W-1:0] view
);
    localparam int NSHIFT = 4;
    logic [ACC_W-1:0] shifted [NSHIFT];

    for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
        assign shifted[s] = res >> s;
    end

    always_comb begin
        unique case (fmt)
            FMT_R0: view = shifted[0];
            FMT_R1: view = shifted[1];
            FMT_R2: view = shifted[2];
            FMT_R3: view = shifted[3];
            FMT_LJ: view = {res[CONV_W-1:0], {(ACC_W-CONV_W){1'b0}}};
            default: view = shifted[0];
        endcase
    end
endmodule

// File: rtl/adc_accum_fmt.sv
module adc_accum_fmt
    import adc_acc_pkg::*;
#(
    parameter int CONV_W    = 10,
    parameter int ACC_W     = 16,
    parameter int MAX_BURST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              burst_en,
    input  logic              conv_done,
    input  logic [CONV_W-1:0] conv_data,
    input  logic              res_we,
    input  logic [ACC_W-1:0]  res_wdata,
    output logic [ACC_W-1:0]  res_rdata,
    output logic              burst_done
);
    localparam int CNT_W = $clog2(MAX_BURST + 1);

    logic             cfg_acc_en;
    fmt_e             cfg_fmt;
    logic [2:0]       cfg_rpt;
    logic             fin;
    logic [ACC_W-1:0] fin_sum, res_q;

    adc_cfg_reg #(.CFG_W(8)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .acc_en(cfg_acc_en), .fmt(cfg_fmt), .rpt(cfg_rpt), .rdata(cfg_rdata)
    );

    adc_burst_seq #(.CONV_W(CONV_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .conv_done(conv_done),
        .conv_data(conv_data), .rpt(cfg_rpt), .fin(fin), .fin_sum(fin_sum),
        .done_q(burst_done)
    );

    adc_result_reg #(.CONV_W(CONV_W), .ACC_W(ACC_W)) u_res (
        .clk(clk), .rst_n(rst_n), .host_we(res_we), .host_wdata(res_wdata),
        .burst_en(burst_en), .conv_done(conv_done), .conv_data(conv_data),
        .acc_en(cfg_acc_en), .fin(fin), .fin_sum(fin_sum), .res_q(res_q)
    );

    adc_read_fmt #(.CONV_W(CONV_W), .ACC_W(ACC_W)) u_fmt (
        .res(res_q), .fmt(cfg_fmt), .view(res_rdata)
    );
endmodule

// File: rtl/adc_accum_fmt_chk.sv
module adc_accum_fmt_chk #(
    parameter int CONV_W = 10,
    parameter int ACC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_rdata,
    input logic              burst_en,
    input logic              conv_done,
    input logic [CONV_W-1:0] conv_data,
    input logic              res_we,
    input logic [ACC_W-1:0]  res_wdata,
    input logic [ACC_W-1:0]  res_rdata,
    input logic              burst_done,
    input logic              acc_en,
    input logic [2:0]        fmt
);
    AST_CFG_CODES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:6] == 2'b00 && cfg_rdata[5:3] <= 3'd4 && cfg_rdata[2:0] <= 3'd5); // R3

    AST_LATEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_en && conv_done && !acc_en && !res_we && !cfg_we && fmt == 3'd0)
        |=> res_rdata == ACC_W'($past(conv_data))); // R4

    AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && res_wdata == '0) |=> res_rdata == '0); // R5

    AST_LJ_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 3'd4) |-> res_rdata[ACC_W-CONV_W-1:0] == '0); // R7

    AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> ($past(conv_done) && $past(burst_en))); // R8

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(burst_en) && !$past(res_we) && !$past(cfg_we) && !burst_done)
        |-> $stable(res_rdata)); // R9
endmodule

bind adc_accum_fmt adc_accum_fmt_chk #(.CONV_W(CONV_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .burst_en(burst_en), .conv_done(conv_done), .conv_data(conv_data),
    .res_we(res_we), .res_wdata(res_wdata), .res_rdata(res_rdata),
    .burst_done(burst_done), .acc_en(cfg_acc_en), .fmt(cfg_fmt)
);

// File: tb/sim_adc_accum_fmt.sv
module sim_adc_accum_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        burst_en = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic        res_we = 1'b0;
    logic [15:0] res_wdata = '0;
    logic [15:0] res_rdata;
    logic        burst_done;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    adc_accum_fmt u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .burst_en(burst_en), .conv_done(conv_done),
        .conv_data(conv_data), .res_we(res_we), .res_wdata(res_wdata),
        .res_rdata(res_rdata), .burst_done(burst_done)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic [15:0] view(input logic [15:0] v, input int f);
        if (f == 4) return {v[9:0], 6'b0};
        if (f < 4)  return v >> f;
        return v;
    endfunction

    task automatic cfg_write(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic res_write(input logic [15:0] v);
        res_we = 1'b1; res_wdata = v;
        @(posedge clk); @(negedge clk);
        res_we = 1'b0;
    endtask

    task automatic conv(input logic [9:0] d, output logic done);
        conv_done = 1'b1; conv_data = d;
        @(posedge clk); @(negedge clk);
        done = burst_done;
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic       d;
        logic [15:0] sum, prev;
        int          n;

        repeat (3) @(negedge clk);
        check("R1 cfg reset", cfg_rdata, 0);
        check("R1 result reset", res_rdata, 0);
        check("R1 done reset", burst_done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // configuration sweep: R2 for legal codes, R3 for reserved ones
        for (int a = 0; a < 2; a++)
            for (int f = 0; f < 8; f++)
                for (int r = 0; r < 8; r++) begin
                    logic [7:0] e;
                    cfg_write({1'b1, a[0], f[2:0], r[2:0]});
                    e = {2'b00, (f <= 4) ? f[2:0] : 3'd0, (r <= 5) ? r[2:0] : 3'd0};
                    if (f <= 4 && r <= 5) check("R2 cfg readback", cfg_rdata, e);
                    else                  check("R3 reserved code", cfg_rdata, e);
                end

        // R4: latest value only
        cfg_write(8'h00);
        foreach (sum[i]) begin
            logic [9:0] x;
            x = 10'((i * 97 + 5) % 1024);
            conv(x, d);
            check("R4 latest sample", res_rdata, {6'b0, x});
        end
        conv(10'h3FF, d);
        check("R4 full-scale sample", res_rdata, 16'h03FF);

        // R6 / R7 / R3: formats over stored patterns
        foreach (prev[k]) begin
            logic [15:0] v;
            v = 16'(k * 16'h1357 + 16'hA5C3);
            if (k > 3) continue;
            res_write(v);
            for (int f = 0; f < 8; f++) begin
                cfg_write({2'b00, f[2:0], 3'b000});
                if (f < 4)       check("R6 right shift", res_rdata, view(v, f));
                else if (f == 4) check("R7 left justify", res_rdata, view(v, 4));
                else             check("R3 reserved fmt as 0", res_rdata, v);
            end
        end

        // R5: accumulate outside burst, host clear
        cfg_write(8'h40);
        res_write(16'h0000);
        check("R5 clear", res_rdata, 0);
        sum = 0;
        for (int i = 0; i < 40; i++) begin
            logic [9:0] x;
            x = 10'((i * 211 + 17) % 1024);
            sum = sum + 16'(x);
            conv(x, d);
            check("R5 running sum", res_rdata, sum);
        end
        res_write(16'h0000);
        check("R5 host write zero", res_rdata, 0);
        conv(10'd123, d);
        check("R5 restart after clear", res_rdata, 123);

        // R8 / R9: each repeat code
        burst_en = 1'b1;
        for (int code = 0; code < 6; code++) begin
            cfg_write({5'b00000, code[2:0]});
            n = (code == 0) ? 1 : (1 << (code + 1));
            prev = res_rdata;
            sum = 0;
            for (int i = 0; i < n; i++) begin
                logic [9:0] x;
                x = 10'((i * 37 + code * 11 + 3) % 1024);
                sum = sum + 16'(x);
                conv(x, d);
                if (i < n - 1) begin
                    check("R9 no early done", d, 0);
                    check("R9 result held", res_rdata, prev);
                end else begin
                    check("R8 done pulse", d, 1);
                    check("R8 burst sum", res_rdata, sum);
                end
            end
            @(negedge clk);
            check("R8 done one cycle", burst_done, 0);
        end

        // R11: full-scale 64-sample burst
        cfg_write(8'h05);
        for (int i = 0; i < 64; i++) conv(10'h3FF, d);
        check("R11 max sum done", d, 1);
        check("R11 max sum", res_rdata, 65472);
        cfg_write(8'h1D);
        check("R11 max sum shifted", res_rdata, 65472 >> 3);

        // R10: abort mid-burst
        cfg_write(8'h02);
        prev = res_rdata;
        for (int i = 0; i < 3; i++) conv(10'd900, d);
        burst_en = 1'b0;
        @(negedge clk);
        check("R10 abort keeps result", res_rdata, prev);
        burst_en = 1'b1;
        sum = 0;
        for (int i = 0; i < 8; i++) begin
            sum = sum + 16'(i + 1);
            conv(10'(i + 1), d);
            if (i == 4) check("R10 no done from stale count", d, 0);
        end
        check("R10 fresh burst done", d, 1);
        check("R10 fresh burst sum", res_rdata, sum);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule